// File: doc/BRIEF.md
# Switch Address-Learning Record Queue

This block sits beside a switch forwarding engine and collects, for each frame the engine handles, the frame's 48-bit source MAC address, an 8-bit hash of that address and the 4-bit number of the ingress port. The hash is computed upstream and arrives ready-made. Each capture becomes one queue entry. Software reads that entry as a pair of 32-bit words through two read-only record registers. A status output tells software when at least one pair is waiting.

The read side follows a fixed order. Software first reads the first-word register and then the second-word register. The second read, and only when it follows a first read of the same pair, removes the pair from the queue. The registers then show the next pair. The queue holds a parameterised number of pairs. A capture that arrives with no room is dropped, and a sticky overflow flag records the loss until a clear strobe resets it.

Top module: `lrn_rec_fifo`

## Requirements
- R1: The first word carries address bytes 1 to 4 in ascending byte lanes. Byte 1 of the address is `push_mac[47:40]` and appears in `rec_a[7:0]`. Byte 2 is `push_mac[39:32]` in `rec_a[15:8]`, byte 3 is `push_mac[31:24]` in `rec_a[23:16]`, and byte 4 is `push_mac[23:16]` in `rec_a[31:24]`.
- R2: The second word carries address byte 5 (`push_mac[15:8]`) in `rec_b[7:0]` and byte 6 (`push_mac[7:0]`) in `rec_b[15:8]`. It also carries the hash in `rec_b[23:16]` and the port number in `rec_b[27:24]`. Bits `rec_b[31:28]` read as zero.
- R3: `pair_avail` is 1 exactly when at least one pair is stored. It rises in the cycle after an accepted push into an empty queue and falls in the cycle after the last pair is removed.
- R4: Pairs come out in the order they were pushed, and up to DEPTH (default 16) pairs are held.
- R5: A pair is removed only by a `rd_rec_b` strobe that comes after a `rd_rec_a` strobe in an earlier cycle for that same pair. A `rd_rec_b` strobe without such a preceding first-word read changes nothing.
- R6: `rec_a` and `rec_b` always show the oldest stored pair. After a removal they show the next pair from the following cycle on.
- R7: While the queue is empty, both record outputs read zero, and read strobes leave the queue state unchanged.
- R8: A push that arrives when the queue is full, with no removal in the same cycle, is dropped and sets `ovf_flag` in the next cycle.
- R9: `ovf_flag` stays set until `ovf_clr` is strobed. If a new overflow occurs in the same cycle as a clear, the flag stays set.
- R10: A push and a removal in the same cycle are both carried out, even when the queue is full. The occupancy is unchanged and no overflow is raised.
- R11: After reset the queue is empty, `pair_avail` and `ovf_flag` are 0, and both record outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Capture strobe from the forwarding engine |
| push_mac | input | 48 | Source address; byte 1 in [47:40] |
| push_hash | input | 8 | Precomputed address hash |
| push_port | input | 4 | Ingress port number |
| rd_rec_a | input | 1 | Read strobe of the first-word register |
| rd_rec_b | input | 1 | Read strobe of the second-word register |
| ovf_clr | input | 1 | Clears the overflow flag |
| pair_avail | output | 1 | At least one pair is waiting |
| rec_a | output | 32 | First word of the oldest pair |
| rec_b | output | 32 | Second word of the oldest pair |
| ovf_flag | output | 1 | Sticky dropped-capture indication |

## Verification
The bench drives several kinds of capture. Addresses with a distinct value in every byte catch any swapped or misplaced byte lane in either word. Runs of several captures, drained only after they are queued, separate true first-in-first-out order from a design that keeps only the newest entry. Second-word strobes with no first-word read before them, and read strobes on an empty queue, show whether removal is gated by the read order. Filling the queue and then pushing once with a removal and once without checks the full boundary: the first case must be accepted silently and the second must be dropped and flagged.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

    localparam int MAC_W  = 48;
    localparam int HASH_W = 8;
    localparam int PORT_W = 4;
    localparam int REC_W  = 32;

    typedef struct packed {
        logic [MAC_W-1:0]  mac;
        logic [HASH_W-1:0] hash;
        logic [PORT_W-1:0] port;
    } lrn_entry_t;

    typedef struct packed {
        logic [REC_W-1:0] a;
        logic [REC_W-1:0] b;
    } lrn_pair_t;

    // Byte n of the address (n = 1..6) sits in mac[55-8n -: 8].
    function automatic logic [7:0] mac_byte(lrn_entry_t e, int n);
        return e.mac[MAC_W-1-8*(n-1) -: 8];
    endfunction

    function automatic lrn_pair_t pack_pair(lrn_entry_t e);
        lrn_pair_t p;
        for (int i = 0; i < 4; i++) begin
            p.a[8*i +: 8] = mac_byte(e, i + 1);
        end
        p.b = {4'h0, e.port, e.hash, mac_byte(e, 6), mac_byte(e, 5)};
        return p;
    endfunction

endpackage

// File: rtl/lrn_pair_store.sv
module lrn_pair_store
    import lrn_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  lrn_entry_t       wr_data,
    input  logic             rd_en,
    output lrn_entry_t       head,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);

    lrn_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            if (wr_en && !rd_en)      cnt <= cnt + 1'b1;
            else if (rd_en && !wr_en) cnt <= cnt - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/lrn_read_ctl.sv
module lrn_read_ctl (
    input  logic clk,
    input  logic rst,
    input  logic rd_first,
    input  logic rd_second,
    input  logic empty,
    output logic pop,
    output logic first_seen
);

    assign pop = rd_second && first_seen && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_seen <= 1'b0;
        end else if (pop) begin
            first_seen <= 1'b0;
        end else if (rd_first && !empty) begin
            first_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/lrn_sticky_flag.sv
module lrn_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/lrn_rec_fifo.sv
module lrn_rec_fifo
    import lrn_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_valid,
    input  logic [47:0] push_mac,
    input  logic [7:0]  push_hash,
    input  logic [3:0]  push_port,
    input  logic        rd_rec_a,
    input  logic        rd_rec_b,
    input  logic        ovf_clr,
    output logic        pair_avail,
    output logic [31:0] rec_a,
    output logic [31:0] rec_b,
    output logic        ovf_flag
);

    lrn_entry_t       in_entry;
    lrn_entry_t       head;
    lrn_pair_t        head_pair;
    logic [CNT_W-1:0] cnt;
    logic             empty;
    logic             full;
    logic             pop;
    logic             a_seen;
    logic             push_ok;
    logic             push_drop;

    assign in_entry = '{mac: push_mac, hash: push_hash, port: push_port};

    lrn_read_ctl u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_first   (rd_rec_a),
        .rd_second  (rd_rec_b),
        .empty      (empty),
        .pop        (pop),
        .first_seen (a_seen)
    );

    // A removal in the same cycle frees the slot a full queue needs.
    assign push_ok   = push_valid && (!full || pop);
    assign push_drop = push_valid && full && !pop;

    lrn_pair_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push_ok),
        .wr_data (in_entry),
        .rd_en   (pop),
        .head    (head),
        .cnt     (cnt),
        .empty   (empty),
        .full    (full)
    );

    lrn_sticky_flag u_ovf (
        .clk  (clk),
        .rst  (rst),
        .set  (push_drop),
        .clr  (ovf_clr),
        .flag (ovf_flag)
    );

    assign head_pair  = pack_pair(head);
    assign pair_avail = !empty;
    assign rec_a      = empty ? '0 : head_pair.a;
    assign rec_b      = empty ? '0 : head_pair.b;

endmodule

// File: rtl/lrn_rec_fifo_chk.sv
module lrn_rec_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_valid,
    input logic             rd_rec_b,
    input logic             ovf_clr,
    input logic             pair_avail,
    input logic [31:0]      rec_a,
    input logic [31:0]      rec_b,
    input logic             ovf_flag,
    input logic             a_seen,
    input logic             pop,
    input logic             full,
    input logic [CNT_W-1:0] cnt
);

    // R3
    push_then_avail_chk: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> pair_avail);

    // R7
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!pair_avail && !push_valid) |=> !pair_avail);

    // R7
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pair_avail |-> (rec_a == '0 && rec_b == '0));

    // R5
    b_alone_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_avail && rd_rec_b && !a_seen) |=> ($stable(rec_a) && $stable(rec_b)));

    // R8
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && full && !pop) |=> (ovf_flag && $stable(cnt)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R10
    push_pop_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop) |=> $stable(cnt));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

endmodule

bind lrn_rec_fifo lrn_rec_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .rd_rec_b   (rd_rec_b),
    .ovf_clr    (ovf_clr),
    .pair_avail (pair_avail),
    .rec_a      (rec_a),
    .rec_b      (rec_b),
    .ovf_flag   (ovf_flag),
    .a_seen     (a_seen),
    .pop        (pop),
    .full       (full),
    .cnt        (cnt)
);

// File: tb/tb_lrn_rec_fifo.sv
module tb_lrn_rec_fifo;
    import lrn_pkg::*;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [47:0] push_mac = '0;
    logic [7:0]  push_hash = '0;
    logic [3:0]  push_port = '0;
    logic        rd_rec_a = 1'b0;
    logic        rd_rec_b = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        pair_avail;
    logic [31:0] rec_a;
    logic [31:0] rec_b;
    logic        ovf_flag;

    lrn_entry_t sb[$];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lrn_rec_fifo #(.DEPTH(DEPTH)) dut (.*);

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] want_a(lrn_entry_t e);
        return {e.mac[23:16], e.mac[31:24], e.mac[39:32], e.mac[47:40]};
    endfunction

    function automatic logic [31:0] want_b(lrn_entry_t e);
        logic [31:0] r = '0;
        r[7:0]   = e.mac[15:8];
        r[15:8]  = e.mac[7:0];
        r[23:16] = e.hash;
        r[27:24] = e.port;
        return r;
    endfunction

    function automatic lrn_entry_t mk(int i);
        lrn_entry_t e;
        e.mac  = {8'h11 + 8'(i), 8'h22 ^ 8'(i), 8'h33, 8'h44 + 8'(i), 8'h55, 8'h66 ^ 8'(3*i)};
        e.hash = 8'hA0 + 8'(i);
        e.port = 4'(i + 1);
        return e;
    endfunction

    // Driver: one capture, queued as expected if there is room.
    task automatic push_frame(lrn_entry_t e, logic with_clr = 1'b0);
        push_valid = 1'b1;
        push_mac   = e.mac;
        push_hash  = e.hash;
        push_port  = e.port;
        ovf_clr    = with_clr;
        @(negedge clk);
        push_valid = 1'b0;
        ovf_clr    = 1'b0;
        if (sb.size() < DEPTH) sb.push_back(e);
    endtask

    // Monitor: compares the head pair against the scoreboard, then reads it out.
    task automatic read_pair(string req);
        lrn_entry_t e = sb.pop_front();
        check({req, " rec_a"}, rec_a, want_a(e));
        check({req, " rec_b"}, rec_b, want_b(e));
        rd_rec_a = 1'b1;
        @(negedge clk);
        rd_rec_a = 1'b0;
        rd_rec_b = 1'b1;
        @(negedge clk);
        rd_rec_b = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        lrn_entry_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 avail", 32'(pair_avail), 32'd0);
        check("R11 rec_a", rec_a, 32'd0);
        check("R11 rec_b", rec_b, 32'd0);
        check("R11 ovf", 32'(ovf_flag), 32'd0);

        // R7 reads on an empty queue
        rd_rec_a = 1'b1; @(negedge clk); rd_rec_a = 1'b0;
        rd_rec_b = 1'b1; @(negedge clk); rd_rec_b = 1'b0;
        check("R7 avail", 32'(pair_avail), 32'd0);
        check("R7 rec_a", rec_a, 32'd0);
        check("R7 rec_b", rec_b, 32'd0);

        // R1 R2 R3 single capture with distinct bytes
        e.mac = 48'hC1_D2_E3_F4_A5_B6; e.hash = 8'h5A; e.port = 4'h9;
        push_frame(e);
        check("R3 avail rise", 32'(pair_avail), 32'd1);
        read_pair("R1 R2 layout");
        check("R3 avail fall", 32'(pair_avail), 32'd0);

        // R5 second-word read without first-word read
        push_frame(mk(1));
        push_frame(mk(2));
        push_frame(mk(3));
        rd_rec_b = 1'b1; @(negedge clk); rd_rec_b = 1'b0;
        check("R5 head kept", rec_a, want_a(mk(1)));
        // R4 R6 order and head advance
        read_pair("R4 R6 order");
        read_pair("R4 R6 order");
        read_pair("R4 R6 order");
        check("R6 drained", 32'(pair_avail), 32'd0);

        // Fill the queue
        for (int i = 0; i < DEPTH; i++) push_frame(mk(10 + i));
        check("R4 full avail", 32'(pair_avail), 32'd1);

        // R10 push and pop together at full
        rd_rec_a = 1'b1; @(negedge clk); rd_rec_a = 1'b0;
        rd_rec_b = 1'b1;
        void'(sb.pop_front());
        push_frame(mk(40));
        rd_rec_b = 1'b0;
        check("R10 no ovf", 32'(ovf_flag), 32'd0);
        check("R10 new head", rec_a, want_a(mk(11)));

        // R8 dropped push at full
        push_frame(mk(50));
        check("R8 ovf set", 32'(ovf_flag), 32'd1);
        @(negedge clk);
        check("R9 sticky", 32'(ovf_flag), 32'd1);
        // R9 clear with simultaneous overflow keeps the flag
        push_frame(mk(51), 1'b1);
        check("R9 set wins", 32'(ovf_flag), 32'd1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R9 cleared", 32'(ovf_flag), 32'd0);

        // R4 R8 drain: dropped captures absent, order kept
        for (int i = 0; i < DEPTH; i++) read_pair("R4 R8 drain");
        check("R4 empty end", 32'(pair_avail), 32'd0);

        summary();
        $finish;
    end

endmodule